// File: doc/BRIEF.md
# Sub-Word Parallel Accumulating ALU

This block is a reconfigurable arithmetic operator for pixel-level image work. Two 40-bit operand words enter together with a configuration that cuts the word into independent lanes: five of 8 bits, four of 10, three of 12, two of 16, or a single 40-bit lane. In every lane the same operation is applied to the matching sub-words of the two operands. The operation is add, subtract, multiply or absolute difference, in signed or unsigned form.

The lane results can be added into a running total held in the output word, one total per lane. A sum-of-absolute-differences step, or a multiply-accumulate step, therefore takes a single operator pass per cycle. The lane split, the operation and the accumulate controls arrive with every valid operand pair, so the operator can be retargeted on any cycle without idle time. The result is registered and appears one clock after the operands, with its own valid flag.

Top module: `swp_alu`

## Requirements
- R1: `cfg_mode` selects the lane split: 0 gives five 8-bit lanes, 1 four 10-bit, 2 three 12-bit, 3 two 16-bit, 4 one 40-bit lane. Lane i of width W takes bits [i*W +: W] of `x`, `y` and `z`.
- R2: `cfg_op` selects the lane operation: 0 is x+y, 1 is x-y, 2 is x*y keeping the low W bits of the product, 3 is |x-y|. No carry or borrow crosses a lane boundary.
- R3: For absolute difference, each operand is widened by one bit (sign extension when `cfg_signed`=1, zero extension when 0), subtracted, and the low W bits of the magnitude are returned.
- R4: With `cfg_acc`=1 and `cfg_clr`=0, each lane of `z` becomes the previous lane value of `z` plus the fresh lane result, modulo 2^W within the lane.
- R5: With `cfg_acc`=1 and `cfg_clr`=1, each lane of `z` is loaded with the fresh lane result. With `cfg_acc`=0, `z` takes the fresh lane results whatever `cfg_clr` is.
- R6: In the 12-bit split, bits 39:36 of `z` are zero after a valid input; in the 16-bit split, bits 39:32 are zero.
- R7: A valid input gives its result on `z` with `out_valid`=1 in the next cycle. A cycle without `in_valid` leaves `z` unchanged and drives `out_valid`=0 in the following cycle.
- R8: A synchronous reset clears `z` to zero and `out_valid` to 0.
- R9: The lane split and operation may differ on consecutive valid cycles, and each one still produces its result one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and configuration are valid this cycle |
| x | input | 40 | First operand word |
| y | input | 40 | Second operand word |
| cfg_mode | input | 3 | Lane split code (R1) |
| cfg_op | input | 2 | Lane operation code (R2) |
| cfg_signed | input | 1 | Signed operands when 1 |
| cfg_acc | input | 1 | Accumulate into the held lanes of z |
| cfg_clr | input | 1 | Restart accumulation from the fresh result |
| out_valid | output | 1 | z holds a new result |
| z | output | 40 | Registered result and accumulator word |

## Verification
The bench builds the block with its default 40-bit word, so all five lane-width variants of the lane unit are elaborated and checked side by side, including the 40-bit multiply and the padded 12- and 16-bit splits. The reference model computes each lane with 64-bit integer arithmetic. Directed runs cover lane-edge carries, extreme signed absolute differences, accumulation wrap and clear, idle cycles and a reset in the middle of a run. A long stretch then changes the split, operation and accumulate controls on every cycle.

// File: rtl/swp_pkg.sv
package swp_pkg;

    localparam int unsigned WORD_W  = 40;
    localparam int unsigned N_MODES = 5;

    typedef enum logic [2:0] {
        MODE_L8  = 3'd0,
        MODE_L10 = 3'd1,
        MODE_L12 = 3'd2,
        MODE_L16 = 3'd3,
        MODE_L40 = 3'd4
    } lane_mode_e;

    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_SUB  = 2'd1,
        OP_MUL  = 2'd2,
        OP_ABSD = 2'd3
    } lane_op_e;

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] z;
    } alu_state_t;

    // lane width of each split code
    function automatic int unsigned lane_width(input int unsigned mode);
        case (mode)
            0:       return 8;
            1:       return 10;
            2:       return 12;
            3:       return 16;
            default: return WORD_W;
        endcase
    endfunction

endpackage

// File: rtl/swp_lane.sv
module swp_lane #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] held_i,
    input  logic [1:0]   op_i,
    input  logic         sgn_i,
    input  logic         acc_i,
    input  logic         clr_i,
    output logic [W-1:0] res_o
);
    import swp_pkg::*;

    localparam logic [W-1:0] ONE = W'(1);

    logic [W:0]   a_ext;
    logic [W:0]   b_ext;
    logic [W:0]   diff_ext;
    logic [W-1:0] mag;
    logic [W-1:0] prod;
    logic [W-1:0] fresh;

    always_comb begin
        a_ext    = {sgn_i & a_i[W-1], a_i};
        b_ext    = {sgn_i & b_i[W-1], b_i};
        diff_ext = a_ext - b_ext;
        mag      = diff_ext[W] ? (~diff_ext[W-1:0] + ONE) : diff_ext[W-1:0];
        prod     = a_i * b_i;
        case (lane_op_e'(op_i))
            OP_ADD:  fresh = a_i + b_i;
            OP_SUB:  fresh = a_i - b_i;
            OP_MUL:  fresh = prod;
            default: fresh = mag;
        endcase
        res_o = (acc_i && !clr_i) ? (held_i + fresh) : fresh;
    end

endmodule

// File: rtl/swp_lane_group.sv
module swp_lane_group #(
    parameter int unsigned LANE_W  = 8,
    parameter int unsigned N_LANES = 5,
    localparam int unsigned USED_W = LANE_W * N_LANES
) (
    input  logic [USED_W-1:0] x_i,
    input  logic [USED_W-1:0] y_i,
    input  logic [USED_W-1:0] held_i,
    input  logic [1:0]        op_i,
    input  logic              sgn_i,
    input  logic              acc_i,
    input  logic              clr_i,
    output logic [USED_W-1:0] res_o
);

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        swp_lane #(.W(LANE_W)) u_lane (
            .a_i    (x_i[i*LANE_W +: LANE_W]),
            .b_i    (y_i[i*LANE_W +: LANE_W]),
            .held_i (held_i[i*LANE_W +: LANE_W]),
            .op_i   (op_i),
            .sgn_i  (sgn_i),
            .acc_i  (acc_i),
            .clr_i  (clr_i),
            .res_o  (res_o[i*LANE_W +: LANE_W])
        );
    end

endmodule

// File: rtl/swp_alu.sv
module swp_alu (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [39:0] x,
    input  logic [39:0] y,
    input  logic [2:0]  cfg_mode,
    input  logic [1:0]  cfg_op,
    input  logic        cfg_signed,
    input  logic        cfg_acc,
    input  logic        cfg_clr,
    output logic        out_valid,
    output logic [39:0] z
);
    import swp_pkg::*;

    alu_state_t        st_d;
    alu_state_t        st_q;
    logic [WORD_W-1:0] grp_res [N_MODES];
    logic [WORD_W-1:0] fresh_word;

    // one lane group per split; the active one is picked below
    for (genvar m = 0; m < N_MODES; m++) begin : g_mode
        localparam int unsigned LW   = lane_width(m);
        localparam int unsigned NL   = WORD_W / LW;
        localparam int unsigned USED = LW * NL;

        logic [USED-1:0] g_res;

        swp_lane_group #(.LANE_W(LW), .N_LANES(NL)) u_group (
            .x_i    (x[USED-1:0]),
            .y_i    (y[USED-1:0]),
            .held_i (st_q.z[USED-1:0]),
            .op_i   (cfg_op),
            .sgn_i  (cfg_signed),
            .acc_i  (cfg_acc),
            .clr_i  (cfg_clr),
            .res_o  (g_res)
        );

        if (USED < WORD_W) begin : g_pad
            assign grp_res[m] = {{(WORD_W-USED){1'b0}}, g_res};
        end else begin : g_full
            assign grp_res[m] = g_res;
        end
    end

    always_comb begin
        case (lane_mode_e'(cfg_mode))
            MODE_L8:  fresh_word = grp_res[0];
            MODE_L10: fresh_word = grp_res[1];
            MODE_L12: fresh_word = grp_res[2];
            MODE_L16: fresh_word = grp_res[3];
            default:  fresh_word = grp_res[4];
        endcase

        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.z = fresh_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign z         = st_q.z;

endmodule

// File: rtl/swp_alu_chk.sv
module swp_alu_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [39:0] x,
    input logic [39:0] y,
    input logic [2:0]  cfg_mode,
    input logic [1:0]  cfg_op,
    input logic        cfg_acc,
    input logic        out_valid,
    input logic [39:0] z
);

    // R7
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(z)));

    // R6
    pad12_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cfg_mode == 3'd2) |=> (z[39:36] == 4'd0));

    // R6
    pad16_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cfg_mode == 3'd3) |=> (z[39:32] == 8'd0));

    // R2
    add40_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cfg_mode == 3'd4 && cfg_op == 2'd0 && !cfg_acc)
        |=> (z == $past(x) + $past(y)));

    // R2
    sub40_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cfg_mode == 3'd4 && cfg_op == 2'd1 && !cfg_acc)
        |=> (z == $past(x) - $past(y)));

endmodule

bind swp_alu swp_alu_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .x         (x),
    .y         (y),
    .cfg_mode  (cfg_mode),
    .cfg_op    (cfg_op),
    .cfg_acc   (cfg_acc),
    .out_valid (out_valid),
    .z         (z)
);

// File: tb/swp_alu_bench.sv
module swp_alu_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [39:0] x = '0;
    logic [39:0] y = '0;
    logic [2:0]  cfg_mode = '0;
    logic [1:0]  cfg_op = '0;
    logic        cfg_signed = 1'b0;
    logic        cfg_acc = 1'b0;
    logic        cfg_clr = 1'b0;
    logic        out_valid;
    logic [39:0] z;

    int          n_checks = 0;
    int          n_errors = 0;
    int          cycles   = 0;
    string       cur_req  = "R8";
    string       exp_req  = "R8";
    logic        exp_vld  = 1'b0;
    logic [39:0] exp_z    = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    swp_alu u_swp_alu (
        .clk(clk), .rst(rst), .in_valid(in_valid), .x(x), .y(y),
        .cfg_mode(cfg_mode), .cfg_op(cfg_op), .cfg_signed(cfg_signed),
        .cfg_acc(cfg_acc), .cfg_clr(cfg_clr), .out_valid(out_valid), .z(z)
    );

    // behavioural lane arithmetic on 64-bit integers
    function automatic logic [39:0] ref_word(
        input logic [39:0] xa, input logic [39:0] ya, input logic [39:0] held,
        input int mode, input int op, input bit sgn, input bit acc, input bit clr);
        int w;
        int n;
        logic [39:0] out;
        case (mode)
            0: w = 8;
            1: w = 10;
            2: w = 12;
            3: w = 16;
            default: w = 40;
        endcase
        n   = 40 / w;
        out = '0;
        for (int i = 0; i < n; i++) begin
            longint mask = (longint'(1) <<< w) - 1;
            longint a  = longint'(xa >> (i*w)) & mask;
            longint b  = longint'(ya >> (i*w)) & mask;
            longint h  = longint'(held >> (i*w)) & mask;
            longint sa = (sgn && ((a >>> (w-1)) & 1) == 1) ? a - (longint'(1) <<< w) : a;
            longint sb = (sgn && ((b >>> (w-1)) & 1) == 1) ? b - (longint'(1) <<< w) : b;
            longint r;
            longint d;
            case (op)
                0: r = (a + b) & mask;
                1: r = (a - b) & mask;
                2: r = (a * b) & mask;
                default: begin
                    d = sa - sb;
                    if (d < 0) d = -d;
                    r = d & mask;
                end
            endcase
            if (acc && !clr) r = (h + r) & mask;
            out = out | (40'(r) << (i*w));
        end
        return out;
    endfunction

    // reference model, advanced on every rising edge
    always @(posedge clk) begin
        exp_req <= cur_req;
        if (rst) begin
            exp_vld <= 1'b0;
            exp_z   <= '0;
        end else begin
            exp_vld <= in_valid;
            if (in_valid)
                exp_z <= ref_word(x, y, exp_z, int'(cfg_mode), int'(cfg_op),
                                  cfg_signed, cfg_acc, cfg_clr);
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        n_checks++;
        if (out_valid !== exp_vld) begin
            n_errors++;
            $display("FAIL %s out_valid actual=%0b expected=%0b", exp_req, out_valid, exp_vld);
        end
        n_checks++;
        if (z !== exp_z) begin
            n_errors++;
            $display("FAIL %s z actual=%h expected=%h", exp_req, z, exp_z);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_errors++;
            $display("FAIL R7 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    task automatic drive(input bit v, input logic [39:0] xa, input logic [39:0] ya,
                         input int mode, input int op, input bit sgn,
                         input bit acc, input bit clr, input string req);
        cur_req    = req;
        in_valid   = v;
        x          = xa;
        y          = ya;
        cfg_mode   = 3'(mode);
        cfg_op     = 2'(op);
        cfg_signed = sgn;
        cfg_acc    = acc;
        cfg_clr    = clr;
        @(negedge clk);
    endtask

    task automatic check_z(input string req, input logic [39:0] expv);
        n_checks++;
        if (z !== expv) begin
            n_errors++;
            $display("FAIL %s fixed z actual=%h expected=%h", req, z, expv);
        end
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R8 reset state
        check_z("R8", 40'h0);
        rst = 1'b0;

        // R2 R1 8-bit add, carries stay in lanes
        drive(1, 40'hFF_FF_FF_FF_FF, 40'h01_01_01_01_01, 0, 0, 0, 0, 0, "R2");
        check_z("R2", 40'h0);
        // R1 10-bit lanes, sub with borrow kept per lane
        drive(1, {10'd0, 10'd5, 10'd0, 10'd3}, {10'd1, 10'd1, 10'd1, 10'd1}, 1, 1, 0, 0, 0, "R1");
        check_z("R1", {10'h3FF, 10'd4, 10'h3FF, 10'd2});
        // R2 multiply low bits, 16-bit
        drive(1, {8'd0, 16'd300, 16'd7}, {8'd0, 16'd300, 16'd9}, 3, 2, 0, 0, 0, "R2");
        check_z("R2", {8'd0, 16'(300*300), 16'd63});
        // R3 signed absolute difference extremes
        drive(1, 40'h80_7F_00_80_05, 40'h7F_80_FF_80_09, 0, 3, 1, 0, 0, "R3");
        check_z("R3", 40'hFF_FF_01_00_04);
        // R3 unsigned absolute difference
        drive(1, 40'h80_7F_00_80_05, 40'h7F_80_FF_80_09, 0, 3, 0, 0, 0, "R3");
        check_z("R3", 40'h01_01_FF_00_04);
        // R6 padding in 12- and 16-bit splits
        drive(1, '1, 40'h0, 2, 0, 0, 0, 0, "R6");
        check_z("R6", 40'h0_FFF_FFF_FFF);
        drive(1, '1, 40'h0, 3, 0, 0, 0, 0, "R6");
        check_z("R6", 40'h00_FFFF_FFFF);
        // R5 clear loads, R4 accumulate with wrap (SAD chain)
        drive(1, 40'h10_20_30_40_F0, 40'h00_00_00_00_00, 0, 3, 0, 1, 1, "R5");
        check_z("R5", 40'h10_20_30_40_F0);
        drive(1, 40'h10_20_30_40_20, 40'h00_00_00_00_00, 0, 3, 0, 1, 0, "R4");
        check_z("R4", 40'h20_40_60_80_10);
        // R7 idle cycles hold z
        drive(0, '1, '1, 0, 0, 0, 1, 0, "R7");
        drive(0, '1, '1, 0, 0, 0, 1, 0, "R7");
        check_z("R7", 40'h20_40_60_80_10);
        // R5 clr ignored without acc
        drive(1, 40'd5, 40'd6, 4, 0, 0, 0, 1, "R5");
        check_z("R5", 40'd11);
        // R9 split changes every cycle
        for (int k = 0; k < 40; k++)
            drive(1, {8'(k*37), 32'(k*32'h9E3779B9)}, {8'(k*11), 32'(k*32'h7F4A7C15)},
                  k % 5, (k / 5) % 4, k[0], k[1], k[2] & k[3], "R9");
        // R8 reset in mid-run
        rst = 1'b1;
        drive(1, '1, '1, 0, 0, 0, 0, 0, "R8");
        check_z("R8", 40'h0);
        rst = 1'b0;
        // R4 long pseudo-random run with mixed controls
        for (int k = 0; k < 600; k++)
            drive(($urandom % 4) != 0, {$urandom, $urandom} & 40'hFF_FFFF_FFFF,
                  {$urandom, $urandom} & 40'hFF_FFFF_FFFF,
                  int'($urandom % 5), int'($urandom % 4), 1'($urandom),
                  ($urandom % 4) != 0, ($urandom % 10) == 0, "R4");
        drive(0, '0, '0, 0, 0, 0, 0, 0, "R7");
        drive(0, '0, '0, 0, 0, 0, 0, 0, "R7");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule